// File: doc/BRIEF.md
# Write-Protect Sequence Detector

This block sits in front of the write engine of a byte-wide nonvolatile memory. It sees every byte write as a one-cycle strobe that carries a block index, an address and a data byte. From that stream it decides, one write at a time, whether the byte may be committed to the array. Several independent memory blocks share the write stream. Each block keeps its own protection flag and its own command matcher.

A block that is protected accepts array updates only inside a window. The window opens with a three-write unlock command. A longer six-write command opens the same kind of window and clears protection. A three-write command sent to an unprotected block opens a window and sets protection. A change to a flag takes effect only when the write engine reports the end of the programming period for that block. The words of a command are never committed. A write that breaks a partial command is treated as ordinary data.

The flags stand in for nonvolatile state. A functional reset leaves them alone. They are loaded from a separate initialisation strobe.

Top module: `wp_guard`

## Requirements
- R1: `commit_o` is registered. It is high in the cycle after a write strobe whose byte may be committed. It is low in every cycle that does not follow a strobe, including the first cycle after reset.
- R2: When the block's flag is clear and no command is in progress, a plain data write is committed.
- R3: When the block's flag is set, a data write with no unlock before it is not committed, and the flag does not change.
- R4: The unlock command is three writes: data 0xAA to address 0x05555, then 0x55 to 0x02AAA, then 0xA0 to 0x05555. Addresses are compared as full 17-bit values and data as 8-bit values. These three writes are not committed. Every later write to that block is committed until the block's `prog_done` pulse.
- R5: A `prog_done` pulse that closes a window opened by the unlock command sets the block's flag. The new value appears in the cycle after the pulse. This holds even if no data byte was written in the window.
- R6: The disable command is six writes: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555. None of the six is committed. Later data writes are committed until `prog_done`, and the flag clears in the cycle after that pulse.
- R7: A write that does not match the next expected command word sends the matcher back to idle. That write is then judged as a plain data write: it is committed exactly when the block's flag is clear.
- R8: A `prot_load` pulse copies `prot_init` into all flags in the next cycle. Reset never changes the flags.
- R9: `wr_blk` selects the block (value i selects block i). Commands, windows and flags of one block do not affect any other block.
- R10: A `prog_done` pulse when the block has no open window leaves both the flag and a partial command unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the matchers and the commit output |
| prot_load | input | 1 | Loads the initial flag values |
| prot_init | input | NUM_BLK | Flag values taken on `prot_load` |
| wr_stb | input | 1 | One-cycle byte-write strobe |
| wr_blk | input | BLK_W | Target block of the write |
| wr_addr | input | ADDR_W | Byte address inside the block |
| wr_data | input | DATA_W | Byte data |
| prog_done | input | NUM_BLK | Per-block end-of-programming pulse from the write engine |
| commit_o | output | 1 | The previous cycle's write may update the array |
| prot_o | output | NUM_BLK | Per-block protection flags |

## Verification
The hardest state to reach is a six-word disable command on one block that runs while the other block is protected. A stray `prog_done` also has to arrive in the middle of a partial command. Only a particular ordering of writes and engine pulses gets there. Directed sequences build these cases explicitly. A random phase then mixes command words, ordinary bytes and end-of-programming pulses across both blocks. This often produces broken and restarted commands, which a bench model of the required behaviour scores write by write.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int unsigned KEY_ADDR_LO = 32'h0000_5555;
    localparam int unsigned KEY_ADDR_HI = 32'h0000_2AAA;
    localparam logic [7:0]  KEY_FIRST   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  KEY_LOCK    = 8'hA0;
    localparam logic [7:0]  KEY_ERASE   = 8'h80;
    localparam logic [7:0]  KEY_OPEN    = 8'h20;

    typedef struct packed {
        logic first_lo;   // 0xAA at 0x5555
        logic second_hi;  // 0x55 at 0x2AAA
        logic lock_lo;    // 0xA0 at 0x5555
        logic erase_lo;   // 0x80 at 0x5555
        logic open_lo;    // 0x20 at 0x5555
    } cmd_hit_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_WIN
    } phase_e;

    typedef enum logic [1:0] {
        PD_NONE, PD_SET, PD_CLR
    } pend_e;

    typedef struct packed {
        phase_e phase;
        pend_e  pend;
        logic   commit;
        logic   prot;
    } trk_t;
endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_hit_t          hit
);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(KEY_ADDR_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(KEY_ADDR_HI);

    logic at_lo, at_hi;

    always_comb begin
        at_lo         = (addr == A_LO);
        at_hi         = (addr == A_HI);
        hit.first_lo  = at_lo && (data == DATA_W'(KEY_FIRST));
        hit.second_hi = at_hi && (data == DATA_W'(KEY_SECOND));
        hit.lock_lo   = at_lo && (data == DATA_W'(KEY_LOCK));
        hit.erase_lo  = at_lo && (data == DATA_W'(KEY_ERASE));
        hit.open_lo   = at_lo && (data == DATA_W'(KEY_OPEN));
    end
endmodule

// File: rtl/wp_seq_tracker.sv
module wp_seq_tracker
    import wp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stb,
    input  cmd_hit_t hit,
    input  logic     done,
    input  logic     init_load,
    input  logic     init_val,
    output logic     commit,
    output logic     prot
);
    trk_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        if (stb) begin
            case (st_q.phase)
                PH_IDLE: if (hit.first_lo) st_d.phase = PH_S1;
                         else st_d.commit = !st_q.prot;                  // R2, R3
                PH_S1:   if (hit.second_hi) st_d.phase = PH_S2;
                         else begin st_d.phase = PH_IDLE; st_d.commit = !st_q.prot; end // R7
                PH_S2:   if (hit.lock_lo) begin
                             st_d.phase = PH_WIN; st_d.pend = PD_SET;    // R4
                         end else if (hit.erase_lo) st_d.phase = PH_S3;
                         else begin st_d.phase = PH_IDLE; st_d.commit = !st_q.prot; end
                PH_S3:   if (hit.first_lo) st_d.phase = PH_S4;
                         else begin st_d.phase = PH_IDLE; st_d.commit = !st_q.prot; end
                PH_S4:   if (hit.second_hi) st_d.phase = PH_S5;
                         else begin st_d.phase = PH_IDLE; st_d.commit = !st_q.prot; end
                PH_S5:   if (hit.open_lo) begin
                             st_d.phase = PH_WIN; st_d.pend = PD_CLR;    // R6
                         end else begin st_d.phase = PH_IDLE; st_d.commit = !st_q.prot; end
                PH_WIN:  st_d.commit = 1'b1;
                default: st_d.phase = PH_IDLE;
            endcase
        end
        // R5, R6, R10: end of programming only acts on an open window
        if (done && st_q.phase == PH_WIN) begin
            st_d.phase = PH_IDLE;
            st_d.pend  = PD_NONE;
            if (st_q.pend == PD_SET) st_d.prot = 1'b1;
            if (st_q.pend == PD_CLR) st_d.prot = 1'b0;
        end
        if (init_load) st_d.prot = init_val;                             // R8
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.pend   <= PD_NONE;
            st_q.commit <= 1'b0;
            st_q.prot   <= init_load ? init_val : st_q.prot;             // R8
        end else begin
            st_q <= st_d;
        end
    end

    assign commit = st_q.commit;
    assign prot   = st_q.prot;
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter  int ADDR_W  = 17,
    parameter  int DATA_W  = 8,
    parameter  int NUM_BLK = 2,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prot_load,
    input  logic [NUM_BLK-1:0] prot_init,
    input  logic               wr_stb,
    input  logic [BLK_W-1:0]   wr_blk,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_BLK-1:0] prog_done,
    output logic               commit_o,
    output logic [NUM_BLK-1:0] prot_o
);
    cmd_hit_t           hit;
    logic [NUM_BLK-1:0] commit_v;

    wp_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_blk
        logic sel;
        assign sel = wr_stb && (wr_blk == BLK_W'(gi));                   // R9
        wp_seq_tracker i_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb       (sel),
            .hit       (hit),
            .done      (prog_done[gi]),
            .init_load (prot_load),
            .init_val  (prot_init[gi]),
            .commit    (commit_v[gi]),
            .prot      (prot_o[gi])
        );
    end

    assign commit_o = |commit_v;                                         // R1
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int NUM_BLK = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_stb,
    input logic               prot_load,
    input logic [NUM_BLK-1:0] prot_init,
    input logic [NUM_BLK-1:0] prog_done,
    input logic               commit_o,
    input logic [NUM_BLK-1:0] prot_o
);
    logic loaded_q = 1'b0;
    always_ff @(posedge clk) if (prot_load) loaded_q <= 1'b1;

    p_commit_after_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(wr_stb));

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && !$past(prot_load) && $past(prog_done) == '0) |-> $stable(prot_o));

    p_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_load |=> (prot_o == $past(prot_init)));

    p_reset_keeps_flags_r8: assert property (@(posedge clk)
        (!rst_n && loaded_q && !prot_load && prog_done == '0) |=> $stable(prot_o));
endmodule

bind wp_guard wp_guard_chk #(.NUM_BLK(NUM_BLK)) i_wp_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .prot_load (prot_load),
    .prot_init (prot_init),
    .prog_done (prog_done),
    .commit_o  (commit_o),
    .prot_o    (prot_o)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prot_load = 1'b0;
    logic [NB-1:0] prot_init = '0;
    logic          wr_stb = 1'b0;
    logic          wr_blk = 1'b0;
    logic [16:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NB-1:0] prog_done = '0;
    logic          commit_o;
    logic [NB-1:0] prot_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model: 0 idle, 1..5 partial command, 6 open window
    int            mst [NB];
    int            mpend [NB];
    logic [NB-1:0] mprot = '0;

    always #2 clk = ~clk;

    wp_guard #(.ADDR_W(17), .DATA_W(8), .NUM_BLK(NB)) i_wp_guard (
        .clk(clk), .rst_n(rst_n), .prot_load(prot_load), .prot_init(prot_init),
        .wr_stb(wr_stb), .wr_blk(wr_blk), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_done(prog_done), .commit_o(commit_o), .prot_o(prot_o)
    );

    function automatic bit mdl_write(int b, logic [16:0] a, logic [7:0] d);
        bit f  = (a == 17'h05555 && d == 8'hAA);
        bit s  = (a == 17'h02AAA && d == 8'h55);
        bit lk = (a == 17'h05555 && d == 8'hA0);
        bit er = (a == 17'h05555 && d == 8'h80);
        bit op = (a == 17'h05555 && d == 8'h20);
        bit c  = 0;
        case (mst[b])
            0: if (f) mst[b] = 1; else c = !mprot[b];
            1: if (s) mst[b] = 2; else begin mst[b] = 0; c = !mprot[b]; end
            2: if (lk) begin mst[b] = 6; mpend[b] = 1; end
               else if (er) mst[b] = 3;
               else begin mst[b] = 0; c = !mprot[b]; end
            3: if (f) mst[b] = 4; else begin mst[b] = 0; c = !mprot[b]; end
            4: if (s) mst[b] = 5; else begin mst[b] = 0; c = !mprot[b]; end
            5: if (op) begin mst[b] = 6; mpend[b] = 2; end
               else begin mst[b] = 0; c = !mprot[b]; end
            default: c = 1;
        endcase
        return c;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int b, logic [16:0] a, logic [7:0] d, string tag);
        bit e;
        e = mdl_write(b, a, d);
        @(negedge clk);
        wr_stb = 1'b1; wr_blk = b[0]; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        chk({31'b0, commit_o}, {31'b0, e}, tag);
    endtask

    task automatic done(int b, string tag);
        if (mst[b] == 6) begin
            if (mpend[b] == 1) mprot[b] = 1'b1;
            if (mpend[b] == 2) mprot[b] = 1'b0;
            mst[b] = 0; mpend[b] = 0;
        end
        @(negedge clk);
        prog_done[b] = 1'b1;
        @(negedge clk);
        prog_done = '0;
        chk({30'b0, prot_o}, {30'b0, mprot}, tag);
    endtask

    task automatic unlock(int b, string tag);
        wr(b, 17'h05555, 8'hAA, tag);
        wr(b, 17'h02AAA, 8'h55, tag);
        wr(b, 17'h05555, 8'hA0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) begin mst[i] = 0; mpend[i] = 0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NB; i++) begin mst[i] = 0; mpend[i] = 0; end
        repeat (2) @(negedge clk);
        prot_load = 1'b1; prot_init = 2'b00;
        @(negedge clk);
        prot_load = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk({31'b0, commit_o}, 0, "R1 reset commit");
        chk({30'b0, prot_o}, 0, "R8 initial load");

        wr(0, 17'h00010, 8'h3C, "R2 plain write");
        @(negedge clk);
        chk({31'b0, commit_o}, 0, "R1 idle cycle");

        unlock(0, "R4 enable words");
        wr(0, 17'h00020, 8'h11, "R4 window data");
        done(0, "R5 set on done");
        chk({30'b0, prot_o}, 32'h1, "R5 flag literal");

        wr(0, 17'h00030, 8'h22, "R3 blocked write");
        chk({30'b0, prot_o}, 32'h1, "R3 flag unchanged");
        wr(1, 17'h00030, 8'h22, "R9 other block writes");

        unlock(0, "R4 unlock protected");
        wr(0, 17'h00040, 8'h33, "R4 protected window");
        wr(0, 17'h00041, 8'h34, "R4 protected window 2");
        done(0, "R5 stays set");

        unlock(1, "R5 enable no data");
        done(1, "R5 empty window");
        chk({30'b0, prot_o}, 32'h3, "R9 both set");

        wr(1, 17'h05555, 8'hAA, "R7 start");
        wr(1, 17'h02AAA, 8'h12, "R7 break protected");

        wr(0, 17'h05555, 8'hAA, "R10 partial");
        done(0, "R10 stray done");
        wr(0, 17'h02AAA, 8'h55, "R10 resume");
        wr(0, 17'h05555, 8'hA0, "R10 resume");
        wr(0, 17'h00050, 8'h44, "R10 window");
        done(0, "R10 close");

        wr(0, 17'h05555, 8'hAA, "R6 word");
        wr(0, 17'h02AAA, 8'h55, "R6 word");
        wr(0, 17'h05555, 8'h80, "R6 word");
        wr(0, 17'h05555, 8'hAA, "R6 word");
        wr(0, 17'h02AAA, 8'h55, "R6 word");
        wr(0, 17'h05555, 8'h20, "R6 word");
        wr(0, 17'h00060, 8'h55, "R6 window data");
        chk({30'b0, prot_o}, 32'h3, "R6 not yet cleared");
        done(0, "R6 clear on done");
        chk({30'b0, prot_o}, 32'h2, "R6 flag literal");

        wr(0, 17'h05555, 8'hAA, "R7 start unprot");
        wr(0, 17'h01234, 8'h55, "R7 break unprot");

        wr(1, 17'h05555, 8'hAA, "R8 partial before reset");
        do_reset();
        @(negedge clk);
        chk({30'b0, prot_o}, 32'h2, "R8 reset keeps flags");
        chk({31'b0, commit_o}, 0, "R1 after reset");
        wr(1, 17'h02AAA, 8'h55, "R8 matcher reset");

        @(negedge clk);
        prot_load = 1'b1; prot_init = 2'b01;
        @(negedge clk);
        prot_load = 1'b0;
        mprot = 2'b01;
        chk({30'b0, prot_o}, 32'h1, "R8 reload");

        for (int n = 0; n < 400; n++) begin
            int b = int'($urandom % NB);
            int op = int'($urandom % 8);
            case (op)
                0: wr(b, 17'h05555, 8'hAA, "R7 random");
                1: wr(b, 17'h02AAA, 8'h55, "R7 random");
                2: wr(b, 17'h05555, 8'hA0, "R4 random");
                3: wr(b, 17'h05555, 8'h80, "R6 random");
                4: wr(b, 17'h05555, 8'h20, "R6 random");
                5, 6: wr(b, 17'($urandom), 8'($urandom), "R2 random");
                default: done(b, "R10 random done");
            endcase
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule